// File: doc/BRIEF.md
# Half-Rate Horizontal YCbCr Decimator

This block reduces one video line of 4:2:2 YCbCr samples to half its horizontal resolution. Before every second sample is dropped, a short symmetric integer low-pass filter runs over luma and over each chroma component. Each component uses only its own samples. A capture window is given in input pixels and is taken at the start of each line. Only the pixels inside that window feed the filters, and at the window edges the missing neighbour taps repeat the nearest sample inside the window. A mode bit, also taken at line start, picks the chroma phase of the output. In co-sited mode the chroma stays on the kept luma positions. In resampled mode the chroma sits halfway between two input chroma positions.

The input arrives one sample per valid cycle in the order Cb, Y, Cr, Y. The results leave on a write-only valid/data pair in the same component order, so a downstream FIFO sees a normal half-width 4:2:2 stream. A 704-pixel window yields 352 luma and 352 chroma samples. The window start must be even. The window length must be a non-zero multiple of four. A new line may begin only after the last group of the previous line has left.

Top module: `hdsc_decim`

## Requirements
- R1: While reset is low, and after it until a group of the first window is ready, out_valid stays low.
- R2: After a line_start cycle, which carries no sample, the valid input samples of the line are Cb, Y, Cr, Y for each pixel pair. The pixel index counts luma samples from 0, and each chroma pair belongs to the even pixel.
- R3: Each output luma at kept pixel k (k - start even) equals clamp((-3·Y[k-2] + 32·Y[k-1] + 70·Y[k] + 32·Y[k+1] - 3·Y[k+2] + 64) >> 7).
- R4: With mode_rs = 0 (co-sited), each output chroma at chroma index c = k/2, for k - start a multiple of 4, uses the same 5-tap kernel over C[c-2..c+2] of its own component.
- R5: With mode_rs = 1 (resampled), each output chroma uses clamp((-C[c-1] + 17·C[c] + 17·C[c+1] - C[c+2] + 16) >> 5) of its own component.
- R6: Only pixels p with win_start <= p < win_stop are used. Samples outside the window have no effect, and a line gives exactly win_stop - win_start output samples.
- R7: A tap index that falls outside the window takes the value of the nearest in-window sample of the same component.
- R8: Each group of four outputs is Cb', Y'(k), Cr', Y'(k+2), with groups in rising k. Each output takes one cycle, and out_valid is never high for more than four cycles in a row.
- R9: Division rounds half up by an arithmetic shift, and every result is clamped to 0..255.
- R10: win_start, win_stop and mode_rs are taken only at line_start. Changing them during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Starts a line and samples the window and the mode |
| mode_rs | input | 1 | 0 co-sited chroma, 1 half-sample-shifted chroma |
| win_start | input | PW | First captured input pixel (even) |
| win_stop | input | PW | First input pixel past the window |
| in_valid | input | 1 | in_data carries a sample |
| in_data | input | 8 | Input sample, order Cb, Y, Cr, Y |
| out_valid | output | 1 | out_data carries a result |
| out_data | output | 8 | Filtered sample, order Cb, Y, Cr, Y |

## Verification
Two functions meet in one cycle: the filter bank takes its snapshot of the tap lines while the next input sample is being shifted into those same lines. Lines are driven with no idle cycles as well as with random gaps, so this overlap happens at every group. A snapshot taken one cycle late would contain a shifted neighbour, and the scoreboard would see a wrong value at that position. A four-pixel window puts the right-edge flush on the same trigger as the first group, and the edge replication there is compared against values the bench computes itself.

// File: rtl/hdsc_pkg.sv
// Shared widths, tap counts and the fixed integer kernels of the decimator.
// Assumes 8-bit unsigned samples. The accumulators are wide enough for the worst-case sums.
package hdsc_pkg;
    localparam int SW     = 8;   // sample width
    localparam int Y_TAPS = 7;   // luma history: k-2 .. k+4
    localparam int C_TAPS = 5;   // chroma history: c-2 .. c+2
    localparam int GROUP  = 4;   // outputs per kept pixel pair

    typedef logic [SW-1:0]      samp_t;
    typedef logic signed [17:0] acc_t;

    localparam acc_t W3   = 18'sd3;
    localparam acc_t W17  = 18'sd17;
    localparam acc_t W32  = 18'sd32;
    localparam acc_t W70  = 18'sd70;
    localparam acc_t RND5 = 18'sd16;
    localparam acc_t RND7 = 18'sd64;
    localparam acc_t MAXV = 18'sd255;

    // Zero-extends a sample into the signed accumulator.
    function automatic acc_t ext(input samp_t s);
        return $signed({10'd0, s});
    endfunction

    // Clamps an accumulator to the 8-bit sample range.
    function automatic samp_t sat_u8(input acc_t v);
        if (v < 0)    return '0;
        if (v > MAXV) return 8'd255;
        return v[SW-1:0];
    endfunction

    // Applies -3/32/70/32/-3 with a /128 round half up.
    function automatic samp_t five_tap(input samp_t a, input samp_t b, input samp_t c,
                                       input samp_t d, input samp_t e);
        acc_t s;
        s = (ext(b) + ext(d)) * W32 + ext(c) * W70 - (ext(a) + ext(e)) * W3 + RND7;
        return sat_u8(s >>> 7);
    endfunction

    // Applies -1/17/17/-1 with a /32 round half up.
    function automatic samp_t four_tap(input samp_t a, input samp_t b, input samp_t c,
                                       input samp_t d);
        acc_t s;
        s = (ext(b) + ext(c)) * W17 - (ext(a) + ext(d)) + RND5;
        return sat_u8(s >>> 5);
    endfunction
endpackage

// File: rtl/hdsc_window_ctl.sv
// Counts the samples of a line and decides which ones enter the tap lines. It also
// decides when a group of four outputs is ready. Assumes the window start is even,
// the window length is a non-zero multiple of four, and line_start carries no sample.
module hdsc_window_ctl #(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          mode_in,
    input  logic [PW-1:0] win_start,
    input  logic [PW-1:0] win_stop,
    input  logic          in_valid,
    output logic          mode_o,
    output logic          y_shift,
    output logic          cb_shift,
    output logic          cr_shift,
    output logic          fill,
    output logic          snap,
    output logic          snap_final
);
    logic [PW:0]   scnt_q;
    logic [PW-1:0] ws_q, we_q;
    logic          act_q;
    logic [1:0]    ph;
    logic [PW-1:0] pix, rel;
    logic          take, fire_n, fire_f;

    // Maps the sample count to a phase and a luma pixel index, then tests the window.
    always_comb begin
        ph       = scnt_q[1:0];
        pix      = {scnt_q[PW:2], (ph == 2'd3)};
        rel      = pix - ws_q;
        take     = in_valid && act_q && (pix >= ws_q) && (pix < we_q);
        y_shift  = take && ph[0];
        cb_shift = take && (ph == 2'd0);
        cr_shift = take && (ph == 2'd2);
        fill     = (rel == '0);
        fire_n   = take && (ph == 2'd2) && (rel[1:0] == 2'd0) && (rel != '0);
        fire_f   = take && (ph == 2'd3) && (({1'b0, pix} + 1'b1) == {1'b0, we_q});
    end

    // Latches the line settings at line start and advances the sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scnt_q <= '0;
            ws_q   <= '0;
            we_q   <= '0;
            mode_o <= 1'b0;
            act_q  <= 1'b0;
        end else if (line_start) begin
            scnt_q <= '0;
            ws_q   <= win_start;
            we_q   <= win_stop;
            mode_o <= mode_in;
            act_q  <= 1'b1;
        end else begin
            if (in_valid && act_q) scnt_q <= scnt_q + 1'b1;
            if (fire_f)            act_q  <= 1'b0;
        end
    end

    // Raises the snapshot strobe one cycle after the trigger sample is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap       <= 1'b0;
            snap_final <= 1'b0;
        end else begin
            snap       <= fire_n || fire_f;
            snap_final <= fire_f;
        end
    end
endmodule

// File: rtl/hdsc_tap_line.sv
// Shift register holding the recent history of one component, newest at index 0.
// "fill" loads every tap with the first in-window sample, which repeats it over the left edge.
// "extend" shows the history shifted by one with the newest repeated, which repeats it over the right edge.
module hdsc_tap_line import hdsc_pkg::*; #(
    parameter int DEPTH = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic                      fill,
    input  logic                      extend,
    input  samp_t                     din,
    output logic [DEPTH-1:0][SW-1:0]  taps_o
);
    logic [DEPTH-1:0][SW-1:0] taps_q;

    // Shifts one sample in, or seeds the whole line at the window start.
    always_ff @(posedge clk) begin
        if (!rst_n)        taps_q <= '0;
        else if (shift_en) taps_q <= fill ? {DEPTH{din}} : {taps_q[DEPTH-2:0], din};
    end

    // Presents either the plain history or the right-edge view.
    assign taps_o = extend ? {taps_q[DEPTH-2:0], taps_q[0]} : taps_q;
endmodule

// File: rtl/hdsc_filter_bank.sv
// Combinational kernels for one group: Cb', Y'(k), Cr', Y'(k+2).
// Assumes the luma taps hold k-2..k+4 (index 6..0) and the chroma taps hold c-2..c+2 (index 4..0).
module hdsc_filter_bank import hdsc_pkg::*; (
    input  logic                        resample,
    input  logic [Y_TAPS-1:0][SW-1:0]   y_t,
    input  logic [C_TAPS-1:0][SW-1:0]   cb_t,
    input  logic [C_TAPS-1:0][SW-1:0]   cr_t,
    output logic [GROUP-1:0][SW-1:0]    res
);
    logic [1:0][C_TAPS-1:0][SW-1:0] c_t;
    samp_t c_out [2];
    samp_t y_out [2];

    assign c_t[0] = cb_t;
    assign c_t[1] = cr_t;

    // One chroma kernel per component; the mode picks the phase.
    for (genvar g = 0; g < 2; g++) begin : g_chroma
        assign c_out[g] = resample
            ? four_tap(c_t[g][3], c_t[g][2], c_t[g][1], c_t[g][0])
            : five_tap(c_t[g][4], c_t[g][3], c_t[g][2], c_t[g][1], c_t[g][0]);
    end

    // Two luma kernels, centred on k (tap 4) and on k+2 (tap 2).
    for (genvar j = 0; j < 2; j++) begin : g_luma
        localparam int B = 2 * (1 - j);
        assign y_out[j] = five_tap(y_t[B+4], y_t[B+3], y_t[B+2], y_t[B+1], y_t[B]);
    end

    assign res[0] = c_out[0];
    assign res[1] = y_out[0];
    assign res[2] = c_out[1];
    assign res[3] = y_out[1];
endmodule

// File: rtl/hdsc_emitter.sv
// Holds one group of results and writes them out one per cycle.
// Assumes a new group is loaded only once the previous one has left.
module hdsc_emitter import hdsc_pkg::*; (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [GROUP-1:0][SW-1:0]  grp,
    output logic                      out_valid,
    output samp_t                     out_data
);
    localparam int CW = $clog2(GROUP + 1);
    localparam int IW = $clog2(GROUP);

    logic [GROUP-1:0][SW-1:0] slots_q;
    logic [CW-1:0]            rem_q;
    logic [IW-1:0]            idx_q;

    // Loads a group, then steps through its slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
        end else if (load) begin
            slots_q <= grp;
            rem_q   <= CW'(GROUP);
            idx_q   <= '0;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign out_valid = (rem_q != '0);
    assign out_data  = slots_q[idx_q];
endmodule

// File: rtl/hdsc_decim.sv
// Top of the half-rate horizontal decimator: window control, three tap lines, the kernels
// and the output sequencer. Assumptions: an even window start, a window length that is a
// multiple of four and at least four, and no line_start while a group is still being written.
module hdsc_decim import hdsc_pkg::*; #(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          mode_rs,
    input  logic [PW-1:0] win_start,
    input  logic [PW-1:0] win_stop,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          out_valid,
    output logic [7:0]    out_data
);
    logic mode_q, y_sh, cb_sh, cr_sh, fill, snap, snap_fin;
    logic [Y_TAPS-1:0][SW-1:0] y_t;
    logic [C_TAPS-1:0][SW-1:0] cb_t, cr_t;
    logic [GROUP-1:0][SW-1:0]  grp;

    hdsc_window_ctl #(.PW(PW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_in(mode_rs),
        .win_start(win_start), .win_stop(win_stop), .in_valid(in_valid),
        .mode_o(mode_q), .y_shift(y_sh), .cb_shift(cb_sh), .cr_shift(cr_sh),
        .fill(fill), .snap(snap), .snap_final(snap_fin)
    );

    hdsc_tap_line #(.DEPTH(Y_TAPS)) u_y (
        .clk(clk), .rst_n(rst_n), .shift_en(y_sh), .fill(fill), .extend(snap_fin),
        .din(in_data), .taps_o(y_t)
    );

    hdsc_tap_line #(.DEPTH(C_TAPS)) u_cb (
        .clk(clk), .rst_n(rst_n), .shift_en(cb_sh), .fill(fill), .extend(snap_fin),
        .din(in_data), .taps_o(cb_t)
    );

    hdsc_tap_line #(.DEPTH(C_TAPS)) u_cr (
        .clk(clk), .rst_n(rst_n), .shift_en(cr_sh), .fill(fill), .extend(snap_fin),
        .din(in_data), .taps_o(cr_t)
    );

    hdsc_filter_bank u_fb (
        .resample(mode_q), .y_t(y_t), .cb_t(cb_t), .cr_t(cr_t), .res(grp)
    );

    hdsc_emitter u_emit (
        .clk(clk), .rst_n(rst_n), .load(snap), .grp(grp),
        .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/hdsc_decim_chk.sv
// Port-level properties of the decimator, attached to every instance by bind.
module hdsc_decim_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_start,
    input logic       out_valid,
    input logic [7:0] out_data
);
    logic [2:0] run_q;
    logic       seen_q;

    // Tracks the length of the current valid run and whether a line has begun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            run_q <= out_valid ? ((run_q != 3'd7) ? run_q + 1'b1 : run_q) : 3'd0;
            if (line_start) seen_q <= 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !out_valid);

    a_r8_burst_max4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_q < 3'd4));

    a_r10_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen_q);

    a_r9_known_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_data));
endmodule

bind hdsc_decim hdsc_decim_chk u_chk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/hdsc_decim_tb.sv
// Scoreboard bench: the driver computes the expected outputs of each line into a queue,
// and a monitor pops and compares each output as it leaves the design.
module hdsc_decim_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PW   = 11;
    localparam int MAXP = 720;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_start = 1'b0;
    logic          mode_rs = 1'b0;
    logic [PW-1:0] win_start = '0;
    logic [PW-1:0] win_stop = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          out_valid;
    logic [7:0]    out_data;

    hdsc_decim #(.PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_rs(mode_rs),
        .win_start(win_start), .win_stop(win_stop), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int v; string tag; } exp_t;

    int    n_chk = 0;
    int    n_bad = 0;
    int    line_outs = 0;
    bit    done = 0;
    string cur_line = "R1";
    int    ymem  [MAXP];
    int    cbmem [MAXP/2];
    int    crmem [MAXP/2];
    exp_t  q[$];
    exp_t  got;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int sat(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic int ref5(input int a, input int b, input int c, input int d, input int e);
        return sat((-3*a + 32*b + 70*c + 32*d - 3*e + 64) >>> 7);
    endfunction

    function automatic int ref4(input int a, input int b, input int c, input int d);
        return sat((-a + 17*b + 17*c - d + 16) >>> 5);
    endfunction

    // R7: clamp a tap position into the window.
    function automatic int yat(input int p, input int s, input int e);
        int pp = (p < s) ? s : ((p > e - 1) ? e - 1 : p);
        return ymem[pp];
    endfunction

    function automatic int cat(input bit red, input int c, input int s, input int e);
        int lo = s / 2;
        int hi = e / 2 - 1;
        int cc = (c < lo) ? lo : ((c > hi) ? hi : c);
        return red ? crmem[cc] : cbmem[cc];
    endfunction

    function automatic int chroma(input bit red, input int c, input int s, input int e, input bit rs);
        if (rs)
            return ref4(cat(red, c-1, s, e), cat(red, c, s, e), cat(red, c+1, s, e), cat(red, c+2, s, e));
        return ref5(cat(red, c-2, s, e), cat(red, c-1, s, e), cat(red, c, s, e),
                    cat(red, c+1, s, e), cat(red, c+2, s, e));
    endfunction

    // R8 order: Cb', Y'(k), Cr', Y'(k+2) per kept pair.
    task automatic build(input int s, input int e, input bit rs);
        for (int k = s; k < e; k += 4) begin
            string ct = rs ? "R5" : "R4";
            q.push_back('{chroma(0, k/2, s, e, rs), ct});
            q.push_back('{ref5(yat(k-2,s,e), yat(k-1,s,e), yat(k,s,e), yat(k+1,s,e), yat(k+2,s,e)), "R3"});
            q.push_back('{chroma(1, k/2, s, e, rs), ct});
            q.push_back('{ref5(yat(k,s,e), yat(k+1,s,e), yat(k+2,s,e), yat(k+3,s,e), yat(k+4,s,e)), "R3"});
        end
    endtask

    task automatic fill_rand();
        for (int i = 0; i < MAXP; i++) ymem[i] = int'($urandom_range(0, 255));
        for (int i = 0; i < MAXP/2; i++) begin
            cbmem[i] = int'($urandom_range(0, 255));
            crmem[i] = int'($urandom_range(0, 255));
        end
    endtask

    // R9: hard 0/255 steps that push the kernels past both ends of the range.
    task automatic fill_extreme();
        for (int i = 0; i < MAXP; i++) ymem[i] = ((i / 2) % 2 == 1) ? 255 : 0;
        for (int i = 0; i < MAXP/2; i++) begin
            cbmem[i] = (i % 2 == 1) ? 255 : 0;
            crmem[i] = ((i / 2) % 2 == 1) ? 0 : 255;
        end
    endtask

    task automatic run_line(input int npix, input int s, input int e, input bit rs,
                            input string tag, input int gap, input bit twist);
        cur_line = tag;
        q.delete();
        build(s, e, rs);
        line_outs = 0;
        @(negedge clk);
        win_start  = PW'(s);
        win_stop   = PW'(e);
        mode_rs    = rs;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < 2*npix; i++) begin
            int pr = i / 4;
            int ph = i % 4;
            int v  = (ph == 0) ? cbmem[pr] : (ph == 1) ? ymem[2*pr] : (ph == 2) ? crmem[pr] : ymem[2*pr+1];
            if (twist && i == 6) begin
                win_start = '0;
                win_stop  = PW'(npix);
                mode_rs   = ~rs;
            end
            in_valid = 1'b1;
            in_data  = 8'(v);
            @(negedge clk);
            in_valid = 1'b0;
            if (gap > 0) repeat ($urandom_range(0, gap)) @(negedge clk);
        end
        repeat (30) @(negedge clk);
        check(q.size() == 0, {tag, " R6 leftover items"}, q.size(), 0);
        check(line_outs == e - s, {tag, " R6 output count"}, line_outs, e - s);
        q.delete();
    endtask

    // Monitor: compares every output against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            line_outs++;
            if (q.size() == 0) begin
                check(1'b0, {cur_line, " R8 unexpected output"}, int'(out_data), -1);
            end else begin
                got = q.pop_front();
                check(int'(out_data) == got.v, {cur_line, " ", got.tag}, int'(out_data), got.v);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1 watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 in reset", int'(out_valid), 0);
        end
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
        end

        fill_rand();
        run_line(32, 8, 24, 1'b0, "R2", 0, 1'b0);
        run_line(32, 8, 24, 1'b1, "R5", 3, 1'b0);
        run_line(32, 0, 4, 1'b0, "R7", 0, 1'b0);
        run_line(32, 12, 16, 1'b1, "R7", 2, 1'b0);
        run_line(32, 28, 32, 1'b0, "R7", 0, 1'b0);
        fill_extreme();
        run_line(32, 0, 32, 1'b0, "R9", 0, 1'b0);
        run_line(32, 4, 28, 1'b1, "R9", 1, 1'b0);
        fill_rand();
        run_line(720, 8, 712, 1'b1, "R6", 0, 1'b0);
        run_line(40, 16, 32, 1'b0, "R10", 2, 1'b1);
        run_line(40, 4, 36, 1'b1, "R10", 0, 1'b1);
        report();
    end
endmodule